// File: doc/BRIEF.md
# Protected-Mode Segment Load Checker

This block decides whether a 16-bit segment selector may be loaded into a segment register. A request carries the selector, the target register class (data, stack or code), the current privilege level and a protected-mode flag. In protected mode the block reads the 8-byte descriptor through a one-byte memory read port. The descriptor comes from the global or the local descriptor table, whichever the selector names. The block then assembles the base and limit, checks type and privilege against the rules for the target class, and reports either the loaded segment state or a fault vector with an error code.

In real mode no descriptor is read. The base is the selector shifted left by four and the limit is 0xFFFFF. A controller pulses `req_valid` while `busy` is low and waits for a one-cycle `done` or `fault` pulse. Result outputs hold their value until the next response.

The memory port has a fixed latency of one cycle: the byte at `mem_addr` is expected on `mem_rdata` in the cycle after `mem_rd_en` is high.

Top module: `seg_load_checker`

## Requirements
- R1: A protected-mode load of a non-null selector that is in range issues exactly 8 single-byte reads. The reads go to addresses table_base + (selector & 0xFFF8) + 0 through +7, in ascending order, one per cycle. Selector bit 2 = 1 selects the local table and bit 2 = 0 selects the global table.
- R2: A selector whose index (selector >> 3) exceeds the limit of the selected table faults with vector 13. Its error code is selector & 0xFFFC and no descriptor bytes are read.
- R3: The base is assembled as {byte7, byte4, byte3, byte2}. The raw limit is {byte6[3:0], byte1, byte0}. When byte6 bit 7 (granularity) is set, the reported limit is (raw << 12) | 0xFFF; otherwise it is the raw limit.
- R4: On success, `seg_attr` returns access byte 5 and `seg_big` returns byte6 bit 6. In that byte, bit 7 is present, bits 6:5 are DPL, bit 4 = 0 means system, bit 3 is executable, bit 2 is conforming and bit 1 is read/write.
- R5: In protected mode, a null selector (selector & 0xFFF8 == 0) loaded into the stack or code class faults with vector 13 and error code 0. Loaded into the data class, it completes with `seg_null` = 1.
- R6: A stack load faults with vector 13 and error code selector & 0xFFFC in any of these cases: the descriptor is a system descriptor; it is not writable (writable means read/write set and executable clear); RPL differs from CPL; or DPL differs from CPL.
- R7: A stack load that passes the R6 checks but whose segment is not present faults with vector 12 and error code selector & 0xFFFC.
- R8: A data load faults with vector 13 and error code selector & 0xFFFC when the descriptor is a system descriptor or is not readable (readable means read/write set or executable clear). If it passes those checks but the segment is not present, it faults with vector 11 and the same error code.
- R9: A code load faults with vector 13 and error code selector & 0xFFFC in any of these cases: the descriptor is a system descriptor; it is not executable; RPL differs from CPL; it is non-conforming and DPL differs from CPL; or it is conforming and DPL exceeds CPL. A code load that passes these checks but is not present faults with vector 11.
- R10: In real mode every class completes with base = selector << 4, limit = 0xFFFFF and `seg_null` = 0, and no memory read is issued.
- R11: `busy` is high from the cycle after a request is accepted until the response. A request seen while `busy` is high is ignored. `done` and `fault` are one-cycle pulses, never both high, and each request gets exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_sel | input | 16 | Selector to load |
| req_kind | input | 2 | Target class: 0 data, 1 stack, 2 code, 3 treated as data |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| cur_pl | input | 2 | Current privilege level |
| gtab_base | input | 32 | Global table base address |
| gtab_limit | input | 16 | Highest valid index in global table |
| ltab_base | input | 32 | Local table base address |
| ltab_limit | input | 16 | Highest valid index in local table |
| mem_rd_en | output | 1 | Byte read strobe |
| mem_addr | output | 32 | Byte read address |
| mem_rdata | input | 8 | Read data, one cycle after strobe |
| busy | output | 1 | Request in progress |
| done | output | 1 | Successful load pulse |
| fault | output | 1 | Fault pulse |
| fault_vec | output | 8 | Fault vector (11, 12 or 13) |
| fault_code | output | 16 | Fault error code |
| seg_base | output | 32 | Loaded segment base |
| seg_limit | output | 32 | Loaded effective limit |
| seg_attr | output | 8 | Loaded access byte |
| seg_big | output | 1 | Default-size bit |
| seg_null | output | 1 | Data register loaded with null selector |

## Verification
A table of selectors is run through each target class, over a descriptor set that isolates one rule per entry:
- a plain read/write data segment;
- a page-granular code segment;
- a non-present segment;
- a system descriptor;
- a read-only data segment;
- a DPL-3 segment;
- one local-table entry.

The same selector is tried against different classes, which separates the per-class rules. For example, a non-present descriptor gives vector 12 for a stack load and vector 11 for a data load, and a read-only segment is accepted as data but refused as stack. Other vectors cover mismatched RPL or CPL, indices just past both table limits, null selectors in each class, and real-mode loads. These tell the privilege, range, null and real-mode paths apart. Directed tests count read strobes and first addresses for each table, confirm that real mode reads nothing, and confirm that a request issued while busy leaves the first result intact.

// File: rtl/seg_load_checker.sv
module seg_load_checker #(
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [15:0]       req_sel,
  input  logic [1:0]        req_kind,
  input  logic              prot_mode,
  input  logic [1:0]        cur_pl,
  input  logic [ADDR_W-1:0] gtab_base,
  input  logic [TLIM_W-1:0] gtab_limit,
  input  logic [ADDR_W-1:0] ltab_base,
  input  logic [TLIM_W-1:0] ltab_limit,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [7:0]        fault_vec,
  output logic [15:0]       fault_code,
  output logic [31:0]       seg_base,
  output logic [31:0]       seg_limit,
  output logic [7:0]        seg_attr,
  output logic              seg_big,
  output logic              seg_null
);
  localparam int          DESC_BYTES = 8;
  localparam int          CNT_W      = $clog2(DESC_BYTES);
  localparam logic [1:0]  K_STACK    = 2'd1;
  localparam logic [1:0]  K_CODE     = 2'd2;
  localparam logic [7:0]  V_NP       = 8'd11;
  localparam logic [7:0]  V_SS       = 8'd12;
  localparam logic [7:0]  V_GP       = 8'd13;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DRAIN, S_EVAL} st_t;

  st_t                     st;
  logic [15:0]             sel_q;
  logic [1:0]              kind_q, cpl_q;
  logic                    prot_q, null_q, inv_q;
  logic [ADDR_W-1:0]       tbase_q;
  logic [CNT_W-1:0]        cnt, cap_idx;
  logic                    cap_v;
  logic [8*DESC_BYTES-1:0] desc_q;

  wire accept = req_valid && (st == S_IDLE);
  wire [ADDR_W-1:0] off_in = ADDR_W'({req_sel[15:3], 3'b000});
  wire [TLIM_W-1:0] lim_in = req_sel[2] ? ltab_limit : gtab_limit;
  wire [ADDR_W-1:0] tab_in = req_sel[2] ? ltab_base : gtab_base;
  wire null_in = (req_sel[15:3] == 13'd0);
  wire inv_in  = ({{(TLIM_W > 13 ? 0 : 13 - TLIM_W){1'b0}}, lim_in} < {{(TLIM_W > 13 ? TLIM_W - 13 : 0){1'b0}}, req_sel[15:3]});

  assign busy      = (st != S_IDLE);
  assign mem_rd_en = (st == S_FETCH);
  assign mem_addr  = tbase_q + ADDR_W'(cnt);

  wire [7:0]  acc      = desc_q[47:40];
  wire [19:0] raw_lim  = {desc_q[51:48], desc_q[15:0]};
  wire [31:0] d_base   = {desc_q[63:56], desc_q[39:16]};
  wire        gran     = desc_q[55];
  wire        d_big    = desc_q[54];
  wire [31:0] eff_lim  = gran ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
  wire        is_exe   = acc[3];
  wire        is_conf  = acc[2];
  wire        rw_bit   = acc[1];
  wire        is_sys   = !acc[4];
  wire [1:0]  dpl      = acc[6:5];
  wire        present  = acc[7];
  wire        wr_ok    = rw_bit && !is_exe;
  wire        rd_ok    = rw_bit || !is_exe;
  wire [1:0]  rpl      = sel_q[1:0];
  wire [15:0] ecode    = {sel_q[15:2], 2'b00};

  logic       v_flt;
  logic [7:0] v_vec;
  logic [15:0] v_code;

  always_comb begin
    v_flt  = 1'b0;
    v_vec  = 8'd0;
    v_code = 16'd0;
    if (!prot_q) begin
      v_flt = 1'b0;
    end else if (null_q) begin
      if (kind_q == K_STACK || kind_q == K_CODE) begin
        v_flt = 1'b1;
        v_vec = V_GP;
      end
    end else if (inv_q) begin
      v_flt  = 1'b1;
      v_vec  = V_GP;
      v_code = ecode;
    end else begin
      case (kind_q)
        K_STACK: begin
          if (is_sys || !wr_ok || rpl != cpl_q || dpl != cpl_q) begin
            v_flt = 1'b1; v_vec = V_GP; v_code = ecode;
          end else if (!present) begin
            v_flt = 1'b1; v_vec = V_SS; v_code = ecode;
          end
        end
        K_CODE: begin
          if (is_sys || !is_exe || rpl != cpl_q ||
              (!is_conf && dpl != cpl_q) || (is_conf && dpl > cpl_q)) begin
            v_flt = 1'b1; v_vec = V_GP; v_code = ecode;
          end else if (!present) begin
            v_flt = 1'b1; v_vec = V_NP; v_code = ecode;
          end
        end
        default: begin
          if (is_sys || !rd_ok) begin
            v_flt = 1'b1; v_vec = V_GP; v_code = ecode;
          end else if (!present) begin
            v_flt = 1'b1; v_vec = V_NP; v_code = ecode;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sel_q   <= '0;
      kind_q  <= '0;
      cpl_q   <= '0;
      prot_q  <= 1'b0;
      null_q  <= 1'b0;
      inv_q   <= 1'b0;
      tbase_q <= '0;
      cnt     <= '0;
      cap_v   <= 1'b0;
      cap_idx <= '0;
      desc_q  <= '0;
    end else begin
      cap_v   <= (st == S_FETCH);
      cap_idx <= cnt;
      if (cap_v) desc_q[8*cap_idx +: 8] <= mem_rdata;
      case (st)
        S_IDLE: if (accept) begin
          sel_q   <= req_sel;
          kind_q  <= req_kind;
          cpl_q   <= cur_pl;
          prot_q  <= prot_mode;
          null_q  <= null_in;
          inv_q   <= inv_in;
          tbase_q <= tab_in + off_in;
          cnt     <= '0;
          st      <= (!prot_mode || null_in || inv_in) ? S_EVAL : S_FETCH;
        end
        S_FETCH: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(DESC_BYTES - 1)) st <= S_DRAIN;
        end
        S_DRAIN: st <= S_EVAL;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_vec  <= '0;
      fault_code <= '0;
      seg_base   <= '0;
      seg_limit  <= '0;
      seg_attr   <= '0;
      seg_big    <= 1'b0;
      seg_null   <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (st == S_EVAL) begin
        done  <= !v_flt;
        fault <= v_flt;
        if (v_flt) begin
          fault_vec  <= v_vec;
          fault_code <= v_code;
        end else if (!prot_q) begin
          seg_base  <= {12'h000, sel_q, 4'h0};
          seg_limit <= 32'h000F_FFFF;
          seg_attr  <= 8'h00;
          seg_big   <= 1'b0;
          seg_null  <= 1'b0;
        end else if (null_q) begin
          seg_base  <= '0;
          seg_limit <= '0;
          seg_attr  <= 8'h00;
          seg_big   <= 1'b0;
          seg_null  <= 1'b1;
        end else begin
          seg_base  <= d_base;
          seg_limit <= eff_lim;
          seg_attr  <= acc;
          seg_big   <= d_big;
          seg_null  <= 1'b0;
        end
      end
    end
  end
endmodule

module seg_load_checker_sva #(
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [15:0]       req_sel,
  input logic [1:0]        req_kind,
  input logic              prot_mode,
  input logic [1:0]        cur_pl,
  input logic [ADDR_W-1:0] gtab_base,
  input logic [TLIM_W-1:0] gtab_limit,
  input logic [ADDR_W-1:0] ltab_base,
  input logic [TLIM_W-1:0] ltab_limit,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_rdata,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [7:0]        fault_vec,
  input logic [15:0]       fault_code,
  input logic [31:0]       seg_base,
  input logic [31:0]       seg_limit,
  input logic [7:0]        seg_attr,
  input logic              seg_big,
  input logic              seg_null
);
  logic real_pend;
  always_ff @(posedge clk) begin
    if (!rst_n) real_pend <= 1'b0;
    else if (done || fault) real_pend <= 1'b0;
    else if (req_valid && !busy && !prot_mode) real_pend <= 1'b1;
  end

  assert_resp_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  assert_resp_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> (!busy && $past(busy)));
  assert_read_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);
  assert_read_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));
  assert_vec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_vec == 8'd11 || fault_vec == 8'd12 || fault_vec == 8'd13));
  assert_stack_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_vec == 8'd12) |-> (fault_code[1:0] == 2'b00));
  assert_real_noread_R10: assert property (@(posedge clk) disable iff (!rst_n)
    real_pend |-> !mem_rd_en);
endmodule

bind seg_load_checker seg_load_checker_sva #(.ADDR_W(ADDR_W), .TLIM_W(TLIM_W)) u_sva (.*);

// File: tb/sim_seg_load_checker.sv
module sim_seg_load_checker;
  localparam int CLK_P = 10;
  localparam int NV    = 22;
  localparam logic [31:0] GBASE = 32'h100;
  localparam logic [31:0] LBASE = 32'h300;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, prot_mode = 1'b1;
  logic [15:0] req_sel = '0;
  logic [1:0]  req_kind = '0, cur_pl = '0;
  logic mem_rd_en, busy, done, fault, seg_big, seg_null;
  logic [31:0] mem_addr, seg_base, seg_limit;
  logic [7:0]  mem_rdata, fault_vec, seg_attr;
  logic [15:0] fault_code;
  logic [7:0]  mem [0:1023];
  int n_chk = 0, n_bad = 0, n_rd = 0, n_resp = 0;
  logic [31:0] first_addr;

  always #(CLK_P/2) clk = ~clk;

  seg_load_checker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_kind(req_kind), .prot_mode(prot_mode), .cur_pl(cur_pl),
    .gtab_base(GBASE), .gtab_limit(16'd6), .ltab_base(LBASE), .ltab_limit(16'd2),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fault(fault), .fault_vec(fault_vec),
    .fault_code(fault_code), .seg_base(seg_base), .seg_limit(seg_limit),
    .seg_attr(seg_attr), .seg_big(seg_big), .seg_null(seg_null));

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr[9:0]];
      if (n_rd == 0) first_addr = mem_addr;
      n_rd = n_rd + 1;
    end
    if (done || fault) n_resp = n_resp + 1;
  end

  // kind[47:46] prot[45] cpl[44:43] sel[42:27] flt[26] vec[25:18] code[17:2] nul[1]
  function automatic logic [47:0] mk(input logic [1:0] k, input logic p, input logic [1:0] c,
      input logic [15:0] s, input logic f, input logic [7:0] v, input logic [15:0] e, input logic n);
    return {k, p, c, s, f, v, e, n, 1'b0};
  endfunction

  localparam logic [47:0] VEC [NV] = '{
    mk(2'd0,1,2'd0,16'h0008,0,8'd0, 16'h0000,0),
    mk(2'd1,1,2'd0,16'h0008,0,8'd0, 16'h0000,0),
    mk(2'd1,1,2'd0,16'h0000,1,8'd13,16'h0000,0),
    mk(2'd0,1,2'd0,16'h0000,0,8'd0, 16'h0000,1),
    mk(2'd2,1,2'd0,16'h0002,1,8'd13,16'h0000,0),
    mk(2'd1,1,2'd0,16'h0018,1,8'd12,16'h0018,0),
    mk(2'd0,1,2'd0,16'h0018,1,8'd11,16'h0018,0),
    mk(2'd0,1,2'd0,16'h0020,1,8'd13,16'h0020,0),
    mk(2'd1,1,2'd0,16'h0028,1,8'd13,16'h0028,0),
    mk(2'd0,1,2'd0,16'h0028,0,8'd0, 16'h0000,0),
    mk(2'd1,1,2'd0,16'h0030,1,8'd13,16'h0030,0),
    mk(2'd1,1,2'd3,16'h0033,0,8'd0, 16'h0000,0),
    mk(2'd1,1,2'd0,16'h0031,1,8'd13,16'h0030,0),
    mk(2'd0,1,2'd0,16'h0038,1,8'd13,16'h0038,0),
    mk(2'd2,1,2'd0,16'h0010,0,8'd0, 16'h0000,0),
    mk(2'd2,1,2'd0,16'h0008,1,8'd13,16'h0008,0),
    mk(2'd0,1,2'd0,16'h000C,0,8'd0, 16'h0000,0),
    mk(2'd0,1,2'd0,16'h0014,1,8'd13,16'h0014,0),
    mk(2'd0,1,2'd0,16'h001C,1,8'd13,16'h001C,0),
    mk(2'd0,0,2'd0,16'h1234,0,8'd0, 16'h0000,0),
    mk(2'd2,1,2'd0,16'h0012,1,8'd13,16'h0010,0),
    mk(2'd1,0,2'd0,16'h0000,0,8'd0, 16'h0000,0)
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 9, 16: return "R3/R4 data load";
      1, 8, 10, 11, 12: return "R6 stack rules";
      2, 3, 4: return "R5 null selector";
      5: return "R7 stack not present";
      6, 7, 17: return "R8 data rules";
      13, 18: return "R2 index limit";
      14, 15, 20: return "R9 code rules";
      default: return "R10 real mode";
    endcase
  endfunction

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] b, input logic [19:0] l,
                          input logic [7:0] ac, input logic g, input logic d);
    mem[a]   = l[7:0];   mem[a+1] = l[15:8];
    mem[a+2] = b[7:0];   mem[a+3] = b[15:8];
    mem[a+4] = b[23:16]; mem[a+5] = ac;
    mem[a+6] = {g, d, 2'b00, l[19:16]};
    mem[a+7] = b[31:24];
  endtask

  task automatic run(input logic [1:0] k, input logic p, input logic [1:0] c,
                     input logic [15:0] s, output logic ok);
    @(negedge clk);
    n_rd = 0; n_resp = 0;
    req_kind = k; prot_mode = p; cur_pl = c; req_sel = s; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ok = 1'b0;
    for (int t = 0; t < 50; t++) begin
      if (done || fault) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (!ok) chk(1'b0, "timeout waiting response", 0, 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic ok;
    logic [47:0] v;
    logic [31:0] ta, xb, xl;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    put_desc(GBASE + 8,  32'h12345678, 20'hABCDE, 8'h92, 1'b0, 1'b1);
    put_desc(GBASE + 16, 32'h00010000, 20'h00012, 8'h9A, 1'b1, 1'b1);
    put_desc(GBASE + 24, 32'h00000000, 20'h0FFFF, 8'h12, 1'b0, 1'b0);
    put_desc(GBASE + 32, 32'h00004000, 20'h00067, 8'h82, 1'b0, 1'b0);
    put_desc(GBASE + 40, 32'h00200000, 20'h000FF, 8'h90, 1'b0, 1'b0);
    put_desc(GBASE + 48, 32'h00300000, 20'h00FFF, 8'hF2, 1'b0, 1'b1);
    put_desc(LBASE + 8,  32'hCAFE0000, 20'h00FFF, 8'h92, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !fault && !mem_rd_en, "R11 reset outputs idle",
        {28'd0, busy, done, fault, mem_rd_en}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      run(v[47:46], v[45], v[44:43], v[42:27], ok);
      if (ok) begin
        if (v[26]) begin
          chk(fault, {tag_of(i), " fault expected"}, {31'd0, fault}, 1);
          chk(fault_vec == v[25:18], {tag_of(i), " vector"}, {24'd0, fault_vec}, {24'd0, v[25:18]});
          chk(fault_code == v[17:2], {tag_of(i), " error code"}, {16'd0, fault_code}, {16'd0, v[17:2]});
        end else begin
          chk(done, {tag_of(i), " done expected"}, {31'd0, done}, 1);
          chk(seg_null == v[1], {tag_of(i), " null flag"}, {31'd0, seg_null}, {31'd0, v[1]});
          if (!v[45]) begin
            xb = {12'd0, v[42:27], 4'd0};
            chk(seg_base == xb, "R10 real base", seg_base, xb);
            chk(seg_limit == 32'hFFFFF, "R10 real limit", seg_limit, 32'hFFFFF);
            chk(n_rd == 0, "R10 no reads in real mode", n_rd, 0);
          end else if (!v[1]) begin
            ta = (v[29] ? LBASE : GBASE) + {16'd0, v[42:30], 3'b000};
            xb = {mem[ta+7], mem[ta+4], mem[ta+3], mem[ta+2]};
            xl = {12'd0, mem[ta+6][3:0], mem[ta+1], mem[ta]};
            if (mem[ta+6][7]) xl = {xl[19:0], 12'hFFF};
            chk(seg_base == xb, {tag_of(i), " R3 base"}, seg_base, xb);
            chk(seg_limit == xl, {tag_of(i), " R3 limit"}, seg_limit, xl);
            chk(seg_attr == mem[ta+5], {tag_of(i), " R4 attr"}, {24'd0, seg_attr}, {24'd0, mem[ta+5]});
            chk(seg_big == mem[ta+6][6], {tag_of(i), " R4 big"}, {31'd0, seg_big}, {31'd0, mem[ta+6][6]});
            chk(n_rd == 8, {tag_of(i), " R1 read count"}, n_rd, 8);
            chk(first_addr == ta, {tag_of(i), " R1 first address"}, first_addr, ta);
          end
        end
        if (v[26] && v[25:18] == 8'd13 && i inside {13, 18})
          chk(n_rd == 0, "R2 no reads when out of range", n_rd, 0);
      end
    end

    // R11 request while busy is ignored
    @(negedge clk);
    n_rd = 0; n_resp = 0;
    req_kind = 2'd0; prot_mode = 1'b1; cur_pl = 2'd0; req_sel = 16'h0008; req_valid = 1'b1;
    @(negedge clk);
    req_sel = 16'h0018; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(n_resp == 1, "R11 single response", n_resp, 1);
    chk(seg_base == 32'h12345678, "R11 first request result kept", seg_base, 32'h12345678);
    chk(n_rd == 8, "R11 busy request adds no reads", n_rd, 8);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule